// File: doc/BRIEF.md
# CRT raster timing generator

This block produces the horizontal and vertical raster timing of a character-clocked display controller. A horizontal counter steps once per character clock (one character is eight pixels wide), and a vertical counter steps once per completed line. From the two counts and a set of programmed limits the block derives horizontal and vertical sync, a display-enable window and a blanking window. It also presents the current character column and scanline to the rest of the display pipeline.

Software programs the geometry through a byte-wide write port into fourteen 8-bit registers. Each quantity is stored with an offset that depends on the axis and the quantity. The vertical quantities are ten bits wide. Their low byte sits in one register, and their upper two bits sit in a two-bit field of a shared overflow register, so the block reassembles each vertical value from two places. The writes land in a pending copy. The whole pending set becomes active at once at the end of a frame, provided it describes a non-empty sync pulse on both axes. A frame is therefore never torn by a partial reprogram.

Top module: `crtc_raster_timer`

## Requirements
- R1: The column counter runs from 0 to (horizontal total register + 4) and then returns to 0. It advances only on a clock edge with `chr_ce` high.
- R2: The line counter advances by one each time the column counter wraps. It runs from 0 to (vertical total register + 1) and then returns to 0.
- R3: `disp_en` is high exactly when column <= horizontal display-end register and line <= vertical display-end register.
- R4: `blank` is high when the column is above the horizontal blank-start register and at or below the horizontal blank-end register. It is also high when the line is at or above the vertical blank-start register and at or below (vertical blank-end register + 1).
- R5: The horizontal sync pulse is active for sync-start <= column < sync-end. The vertical sync pulse is active for sync-start <= line < sync-end.
- R6: Register 13 bit 7 set makes `hsync` active-low, and register 13 bit 6 set makes `vsync` active-low. When a bit is clear, the matching sync is active-high.
- R7: The registers are mapped as follows. Horizontal total, display-end, blank-start, blank-end, sync-start and sync-end sit at addresses 0 to 5. The low bytes of the same six vertical quantities sit at addresses 6 to 11. The upper two bits of vertical fields 0 to 3 sit in register 12, at bits [1:0], [3:2], [5:4] and [7:6]. The upper two bits of vertical fields 4 and 5 sit in register 13, at bits [1:0] and [3:2]. Writes to addresses 14 and 15 are dropped.
- R8: Register writes take effect as a whole set on the clock edge that ends a frame. That is the advancing edge with the column and the line both at their limits. Until then the running frame keeps its old timing.
- R9: A pending set whose horizontal or vertical sync end equals its sync start is not adopted at the frame end. The previously active set stays in force.
- R10: After reset both counters are 0 and the active set is all zero. This gives a 5-column by 2-line frame with no sync pulse, with display enabled only at column 0 and line 0, and with blank high on every position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chr_ce | input | 1 | Character clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| hsync | output | 1 | Horizontal sync, polarity per R6 |
| vsync | output | 1 | Vertical sync, polarity per R6 |
| disp_en | output | 1 | Active display window |
| blank | output | 1 | Blanking window |
| col | output | 9 | Current character column |
| line | output | 11 | Current scanline |

## Verification
The two functions that can fall in the same cycle are a register write and the frame-end commit. A write that lands on the commit edge must not join the set being adopted. A write that lands in the middle of a frame must leave the rest of that frame untouched. The bench provokes both cases by issuing writes from a parallel process while every position of the running frame is checked against the old geometry. It then checks the following frame against the new geometry. A pending set with a zero-length sync is injected the same way, and the frame after it must still show the old pulses.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int HW       = 8;
  localparam int VW       = 10;
  localparam int HCW      = HW + 1;
  localparam int VCW      = VW + 1;
  localparam int AW       = 4;
  localparam int NFLD     = 6;
  localparam int H_BASE   = 0;
  localparam int V_BASE   = H_BASE + NFLD;
  localparam int VHI      = VW - 8;
  localparam int FPR      = 8 / VHI;
  localparam int OVF_BASE = V_BASE + NFLD;
  localparam int NREG     = OVF_BASE + 2;
  localparam int POL_REG  = OVF_BASE + 1;
  localparam int HNEG_BIT = 7;
  localparam int VNEG_BIT = 6;
  localparam int HTOT_OFS = 4;
  localparam int VTOT_OFS = 1;

  localparam int F_TOT = 0;
  localparam int F_DE  = 1;
  localparam int F_BS  = 2;
  localparam int F_BE  = 3;
  localparam int F_SS  = 4;
  localparam int F_SE  = 5;

  typedef logic [NREG-1:0][7:0] crtc_regs_t;

  typedef struct packed {
    logic [NFLD-1:0][HW-1:0] h;
    logic [NFLD-1:0][VW-1:0] v;
    logic                    hneg;
    logic                    vneg;
  } crtc_timing_t;

  function automatic crtc_timing_t crtc_unpack(input crtc_regs_t r);
    crtc_timing_t t;
    for (int i = 0; i < NFLD; i++) begin
      t.h[i] = r[H_BASE + i][HW-1:0];
      t.v[i] = {r[OVF_BASE + i / FPR][(i % FPR) * VHI +: VHI], r[V_BASE + i]};
    end
    t.hneg = r[POL_REG][HNEG_BIT];
    t.vneg = r[POL_REG][VNEG_BIT];
    return t;
  endfunction

  function automatic logic crtc_set_ok(input crtc_timing_t t);
    return (t.h[F_SE] != t.h[F_SS]) && (t.v[F_SE] != t.v[F_SS]);
  endfunction
endpackage

// File: rtl/crtc_counter.sv
module crtc_counter #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_n;
  logic         at_lim;

  assign at_lim = (cnt == limit);
  assign wrap   = adv && at_lim;

  always_comb begin
    cnt_n = cnt;
    if (adv) cnt_n = at_lim ? '0 : cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

  // R1 / R2: the count never passes the programmed limit
  a_r1_cnt_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= limit);

  // R1 / R2: the count moves only after an advance request
  a_r2_cnt_moves_on_adv: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> $past(adv));
endmodule

// File: rtl/crtc_regfile.sv
module crtc_regfile
  import crtc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          frame_end,
  output crtc_timing_t  tim
);
  crtc_regs_t   shd_q, shd_n;
  crtc_regs_t   act_q, act_n;
  crtc_timing_t pend;

  assign pend = crtc_unpack(shd_q);
  assign tim  = crtc_unpack(act_q);

  always_comb begin
    shd_n = shd_q;
    if (wr_en && (wr_addr < AW'(NREG))) shd_n[wr_addr] = wr_data;
  end

  always_comb begin
    act_n = act_q;
    if (frame_end && crtc_set_ok(pend)) act_n = shd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= '0;
      act_q <= '0;
    end else begin
      shd_q <= shd_n;
      act_q <= act_n;
    end
  end

  // R8: the active set only changes on a frame-end edge
  a_r8_commit_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q != $past(act_q)) |-> $past(frame_end));

  // R9: an adopted set always carries non-empty sync pulses
  a_r9_adopted_has_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q != $past(act_q)) |-> ((tim.h[F_SE] != tim.h[F_SS]) && (tim.v[F_SE] != tim.v[F_SS])));
endmodule

// File: rtl/crtc_decode.sv
module crtc_decode
  import crtc_pkg::*;
(
  input  logic [HCW-1:0] hcnt,
  input  logic [VCW-1:0] vcnt,
  input  crtc_timing_t   tim,
  output logic           hsync,
  output logic           vsync,
  output logic           disp_en,
  output logic           blank
);
  logic [HCW-1:0] h_de, h_bs, h_be, h_ss, h_se;
  logic [VCW-1:0] v_de, v_bs, v_be1, v_ss, v_se;
  logic           h_act, v_act, h_blk, v_blk, h_syn, v_syn;

  always_comb begin
    h_de  = HCW'(tim.h[F_DE]);
    h_bs  = HCW'(tim.h[F_BS]);
    h_be  = HCW'(tim.h[F_BE]);
    h_ss  = HCW'(tim.h[F_SS]);
    h_se  = HCW'(tim.h[F_SE]);
    v_de  = VCW'(tim.v[F_DE]);
    v_bs  = VCW'(tim.v[F_BS]);
    v_be1 = VCW'(tim.v[F_BE]) + VCW'(1);
    v_ss  = VCW'(tim.v[F_SS]);
    v_se  = VCW'(tim.v[F_SE]);
  end

  assign h_act   = (hcnt <= h_de);
  assign v_act   = (vcnt <= v_de);
  assign h_blk   = (hcnt > h_bs) && (hcnt <= h_be);
  assign v_blk   = (vcnt >= v_bs) && (vcnt <= v_be1);
  assign h_syn   = (hcnt >= h_ss) && (hcnt < h_se);
  assign v_syn   = (vcnt >= v_ss) && (vcnt < v_se);

  assign disp_en = h_act && v_act;
  assign blank   = h_blk || v_blk;
  assign hsync   = h_syn ^ tim.hneg;
  assign vsync   = v_syn ^ tim.vneg;
endmodule

// File: rtl/crtc_raster_timer.sv
module crtc_raster_timer
  import crtc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           chr_ce,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [7:0]     wr_data,
  output logic           hsync,
  output logic           vsync,
  output logic           disp_en,
  output logic           blank,
  output logic [HCW-1:0] col,
  output logic [VCW-1:0] line
);
  crtc_timing_t   tim;
  logic [HCW-1:0] h_lim;
  logic [VCW-1:0] v_lim;
  logic           h_wrap, v_wrap;

  assign h_lim = HCW'(tim.h[F_TOT]) + HCW'(HTOT_OFS);
  assign v_lim = VCW'(tim.v[F_TOT]) + VCW'(VTOT_OFS);

  crtc_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .frame_end (v_wrap),
    .tim       (tim)
  );

  crtc_counter #(.W(HCW)) u_hcnt (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (chr_ce),
    .limit (h_lim),
    .cnt   (col),
    .wrap  (h_wrap)
  );

  crtc_counter #(.W(VCW)) u_vcnt (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (h_wrap),
    .limit (v_lim),
    .cnt   (line),
    .wrap  (v_wrap)
  );

  crtc_decode u_dec (
    .hcnt    (col),
    .vcnt    (line),
    .tim     (tim),
    .hsync   (hsync),
    .vsync   (vsync),
    .disp_en (disp_en),
    .blank   (blank)
  );
endmodule

// File: tb/sim_crtc_raster_timer.sv
module sim_crtc_raster_timer;
  logic        clk = 1'b0;
  logic        rst_n, chr_ce, wr_en;
  logic [3:0]  wr_addr;
  logic [7:0]  wr_data;
  logic        hsync, vsync, disp_en, blank;
  logic [8:0]  col;
  logic [10:0] line;

  int checks = 0;
  int errors = 0;
  int m_h[6];
  int m_v[6];
  bit m_hneg, m_vneg;

  always #4 clk = ~clk;

  crtc_raster_timer u0 (
    .clk(clk), .rst_n(rst_n), .chr_ce(chr_ce), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .hsync(hsync), .vsync(vsync),
    .disp_en(disp_en), .blank(blank), .col(col), .line(line)
  );

  function automatic void report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    report();
    $finish;
  end

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // R7 register layout
  task automatic program_all();
    for (int i = 0; i < 6; i++) wr(i, m_h[i] & 255);
    for (int i = 0; i < 6; i++) wr(6 + i, m_v[i] & 255);
    wr(12, ((m_v[3] >> 8) << 6) | ((m_v[2] >> 8) << 4) | ((m_v[1] >> 8) << 2) | (m_v[0] >> 8));
    wr(13, (int'(m_hneg) << 7) | (int'(m_vneg) << 6) | ((m_v[5] >> 8) << 2) | (m_v[4] >> 8));
  endtask

  task automatic wait_frame_start();
    while (col == 0 && line == 0) @(negedge clk);
    while (!(col == 0 && line == 0)) @(negedge clk);
  endtask

  task automatic check_pt(input int hc, input int vc, input string tag);
    logic [23:0] exp_v, act_v;
    logic de, bl, hs, vs;
    de = (hc <= m_h[1]) && (vc <= m_v[1]);
    bl = ((hc > m_h[2]) && (hc <= m_h[3])) || ((vc >= m_v[2]) && (vc <= m_v[3] + 1));
    hs = ((hc >= m_h[4]) && (hc < m_h[5])) ^ m_hneg;
    vs = ((vc >= m_v[4]) && (vc < m_v[5])) ^ m_vneg;
    exp_v = {9'(hc), 11'(vc), de, bl, hs, vs};
    act_v = {col, line, disp_en, blank, hsync, vsync};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s R1/R2/R3/R4/R5/R6 at (%0d,%0d): actual %h expected %h", tag, hc, vc, act_v, exp_v);
    end
  endtask

  // walks one whole frame from (0,0) and checks the wrap back to (0,0)
  task automatic run_frame(input string tag);
    int ht, vt;
    ht = m_h[0] + 5;
    vt = m_v[0] + 2;
    for (int vc = 0; vc < vt; vc++)
      for (int hc = 0; hc < ht; hc++) begin
        check_pt(hc, vc, tag);
        @(negedge clk);
      end
    checks++;
    if (col !== 9'd0 || line !== 11'd0) begin
      errors++;
      $display("FAIL %s R8 frame wrap: actual (%0d,%0d) expected (0,0)", tag, col, line);
    end
  endtask

  task automatic t_reset();
    checks++;
    if (col !== 0 || line !== 0 || disp_en !== 1'b1 || blank !== 1'b1 || hsync !== 1'b0 || vsync !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset state: actual %h expected %h",
               {col, line, disp_en, blank, hsync, vsync}, {20'd0, 4'b1100});
    end
    for (int i = 0; i < 6; i++) begin m_h[i] = 0; m_v[i] = 0; end
    m_hneg = 0; m_vneg = 0;
    run_frame("R10 zero set");
  endtask

  task automatic t_mode_a();
    m_h = '{7, 7, 7, 11, 9, 10};
    m_v = '{4, 3, 4, 4, 4, 5};
    program_all();
    wait_frame_start();
    run_frame("R7 mode A");
    run_frame("R3 mode A repeat");
  endtask

  task automatic t_polarity();
    m_hneg = 1; m_vneg = 1;
    wr(13, 8'hC0);
    wait_frame_start();
    run_frame("R6 active-low");
  endtask

  task automatic t_midframe();
    fork
      run_frame("R8 old timing holds");
      begin repeat (20) @(negedge clk); wr(0, 11); end
    join
    m_h[0] = 11;
    run_frame("R8 new total");
  endtask

  task automatic t_reject();
    fork
      run_frame("R9 before bad set");
      begin repeat (5) @(negedge clk); wr(5, m_h[4]); end
    join
    run_frame("R9 bad set refused");
    fork
      run_frame("R9 during restore");
      begin repeat (5) @(negedge clk); wr(5, m_h[5]); end
    join
    run_frame("R9 after restore");
  endtask

  task automatic t_hold();
    int c0, l0;
    repeat (3) @(negedge clk);
    chr_ce = 1'b0;
    c0 = col; l0 = line;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      checks++;
      if (col !== 9'(c0) || line !== 11'(l0)) begin
        errors++;
        $display("FAIL R1 hold with chr_ce low: actual (%0d,%0d) expected (%0d,%0d)", col, line, c0, l0);
      end
    end
    chr_ce = 1'b1;
    @(negedge clk);
    checks++;
    if (col !== 9'((c0 + 1) % (m_h[0] + 5))) begin
      errors++;
      $display("FAIL R1 resume: actual %0d expected %0d", col, (c0 + 1) % (m_h[0] + 5));
    end
  endtask

  task automatic t_overflow();
    m_v = '{258, 3, 4, 4, 256, 258};
    m_hneg = 0; m_vneg = 0;
    program_all();
    wr(14, 8'hFF);
    wr(15, 8'hFF);
    wait_frame_start();
    run_frame("R7 high vertical bits");
  endtask

  initial begin
    rst_n = 1'b0; chr_ce = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mode_a();
    t_polarity();
    t_midframe();
    t_reject();
    t_hold();
    t_overflow();
    report();
    $finish;
  end
endmodule